// File: doc/BRIEF.md
# NAND Hamming Parity Accumulator

This block watches the data beats that pass between a memory controller and a NAND device. It builds the single-error-correcting Hamming parity of one data block as the bytes go by. Each byte gets an index within the block. Each data bit then has a 12-bit address formed as {byte index, bit number}. For every address bit k, the block keeps two running parities: an even one over all set data bits whose address bit k is 0, and an odd one over those whose address bit k is 1. Levels 0 to 2 are the column parities (P1, P2, P4). Levels 3 to 11 are the row parities (P8 to P2048).

Software clears the block, selects the bus width, picks which chip select to watch and sets the block length. It then lets the page transfer run. When the programmed number of bytes has been absorbed, the result-valid flag rises. From then on the result stays frozen until the next clear. Software compares the code computed on a read against the code stored at write time. Locating and fixing a bad bit from the difference is done elsewhere.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, `result_o` and `code_o` are zero and `valid_o` is low.
- R2: Even parity of level k sits at `result_o[k]` and odd parity of level k at `result_o[16+k]`, for k = 0..11. Bits 15:12 and 31:28 are zero. A bit at byte index i, bit j has address {i, j}, with j in the three low bits. It feeds the odd parity of every level whose address bit is 1 and the even parity of every other level.
- R3: `code_o[7:0]` equals `result_o[7:0]`, `code_o[15:8]` equals `result_o[23:16]`, and `code_o[23:16]` equals {`result_o[27:24]`, `result_o[11:8]`}.
- R4: The code is not inverted: a full 512-byte block of 0xFF bytes gives a result of zero.
- R5: With `x16_i` high, a beat carries two bytes. `beat_data_i[7:0]` takes byte index n and `beat_data_i[15:8]` takes n+1. With `x16_i` low, only `beat_data_i[7:0]` is used, as one byte.
- R6: A beat is absorbed only when `beat_cs_i` equals `sel_cs_i`. Beats for other chip selects leave the result unchanged.
- R7: While `en_i` is low, no beat is absorbed and the result and the byte count are unchanged.
- R8: The block length is 2×(`size_i`+1) bytes. `valid_o` rises in the cycle after the beat that delivers the last byte. Beats after that are ignored, and the result holds until a clear.
- R9: A one-cycle `clr_i` zeroes the result, the byte count and `valid_o`. It wins over a beat presented in the same cycle, and that beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Clear pulse for parities, count and valid flag |
| en_i | input | 1 | Accumulation enable |
| x16_i | input | 1 | Bus width: 1 = 16-bit beats, 0 = 8-bit beats |
| sel_cs_i | input | 3 | Chip select being watched |
| size_i | input | 8 | Block length code: bytes/2 − 1 |
| beat_vld_i | input | 1 | A data beat is on the bus this cycle |
| beat_cs_i | input | 3 | Chip select of the current beat |
| beat_data_i | input | 16 | Beat data, low byte first |
| result_o | output | 32 | Packed even/odd parity word |
| code_o | output | 24 | Three code bytes, first byte in bits 7:0 |
| valid_o | output | 1 | Block complete, result final |

## Verification
The bench targets the following corner cases:
- **Single set bit at index 0.** This must light all twelve even parities. A design that swaps the even and odd sense would show the pattern in the upper half-word instead.
- **Mixed 16-bit beat.** This catches a lane swap or a wrong index for the high byte, because the row parities then disagree.
- **All-0xFF page.** This must give zero. An inverted code would give all ones in the used fields.
- **Beats after completion, and a clear that coincides with a beat.** These expose a counter that runs past the block length, or a clear that loses to the data path.

// File: rtl/nhe_pkg.sv
package nhe_pkg;

  localparam int COL_LEVELS = 3;

  // Bits of a byte whose bit-number bit k is one (odd half of column level k).
  function automatic logic [7:0] col_mask(input int k);
    logic [7:0] m;
    m = '0;
    for (int j = 0; j < 8; j++) begin
      if (((j >> k) & 1) == 1) m[j] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/nhe_lane.sv
module nhe_lane #(
  parameter int ADDR_W = 9,
  parameter int LV     = ADDR_W + 3
) (
  input  logic              act_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [7:0]        byte_i,
  output logic [LV-1:0]     even_o,
  output logic [LV-1:0]     odd_o
);
  import nhe_pkg::*;

  logic bpar;
  assign bpar = ^byte_i;

  for (genvar k = 0; k < COL_LEVELS; k++) begin : g_col
    assign odd_o[k]  = act_i & (^(byte_i &  col_mask(k)));
    assign even_o[k] = act_i & (^(byte_i & ~col_mask(k)));
  end

  for (genvar k = COL_LEVELS; k < LV; k++) begin : g_row
    assign odd_o[k]  = act_i &  idx_i[k-COL_LEVELS] & bpar;
    assign even_o[k] = act_i & ~idx_i[k-COL_LEVELS] & bpar;
  end

endmodule

// File: rtl/nhe_count.sv
module nhe_count #(
  parameter int ADDR_W = 9,
  parameter int SIZE_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              req_i,
  input  logic              x16_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              valid_o
);
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, total, step, cnt_sum;
  logic             valid_q, valid_d, upd;

  always_comb begin
    total   = (CNT_W'(size_i) + CNT_W'(1)) << 1;
    step    = x16_i ? CNT_W'(2) : CNT_W'(1);
    cnt_sum = cnt_q + step;
    take_o  = req_i & ~clr_i & ~valid_q & (cnt_sum <= total);
    upd     = clr_i | take_o;
    if (clr_i) begin
      cnt_d   = '0;
      valid_d = 1'b0;
    end else begin
      cnt_d   = cnt_sum;
      valid_d = (cnt_sum == total);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (upd) begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign idx_o   = cnt_q[ADDR_W-1:0];
  assign valid_o = valid_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (cnt_q == $past(cnt_q) + $past(step)));               // R8
  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> (cnt_q == $past(total)));                     // R8

endmodule

// File: rtl/nhe_accum.sv
module nhe_accum #(
  parameter int LV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          take_i,
  input  logic [LV-1:0] add_e_i,
  input  logic [LV-1:0] add_o_i,
  output logic [LV-1:0] acc_e_o,
  output logic [LV-1:0] acc_o_o
);
  logic [LV-1:0] e_q, o_q, e_d, o_d;
  logic          upd;

  always_comb begin
    upd = clr_i | take_i;
    if (clr_i) begin
      e_d = '0;
      o_d = '0;
    end else begin
      e_d = e_q ^ add_e_i;
      o_d = o_q ^ add_o_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= '0;
      o_q <= '0;
    end else if (upd) begin
      e_q <= e_d;
      o_q <= o_d;
    end
  end

  assign acc_e_o = e_q;
  assign acc_o_o = o_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (e_q == '0 && o_q == '0));                              // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !take_i) |=> ($stable(e_q) && $stable(o_q)));          // R7

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int ADDR_W = 9,
  parameter int CS_W   = 3,
  parameter int SIZE_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              x16_i,
  input  logic [CS_W-1:0]   sel_cs_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              beat_vld_i,
  input  logic [CS_W-1:0]   beat_cs_i,
  input  logic [15:0]       beat_data_i,
  output logic [31:0]       result_o,
  output logic [23:0]       code_o,
  output logic              valid_o
);
  localparam int LV = ADDR_W + 3;

  // Reset: asserted at once, released through two flops.
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic              req, take;
  logic [ADDR_W-1:0] idx0, idx1;
  logic [LV-1:0]     e0, o0, e1, o1, acc_e, acc_o;

  assign req  = en_i & beat_vld_i & (beat_cs_i == sel_cs_i);
  assign idx1 = idx0 + ADDR_W'(1);

  nhe_count #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .clr_i(clr_i), .req_i(req), .x16_i(x16_i),
    .size_i(size_i), .take_o(take), .idx_o(idx0), .valid_o(valid_o)
  );

  nhe_lane #(.ADDR_W(ADDR_W), .LV(LV)) u_lane_lo (
    .act_i(take), .idx_i(idx0), .byte_i(beat_data_i[7:0]),
    .even_o(e0), .odd_o(o0)
  );

  nhe_lane #(.ADDR_W(ADDR_W), .LV(LV)) u_lane_hi (
    .act_i(take & x16_i), .idx_i(idx1), .byte_i(beat_data_i[15:8]),
    .even_o(e1), .odd_o(o1)
  );

  nhe_accum #(.LV(LV)) u_acc (
    .clk(clk), .rst_n(rst_sn), .clr_i(clr_i), .take_i(take),
    .add_e_i(e0 ^ e1), .add_o_i(o0 ^ o1), .acc_e_o(acc_e), .acc_o_o(acc_o)
  );

  always_comb begin
    result_o = '0;
    result_o[LV-1:0]       = acc_e;
    result_o[16+LV-1:16]   = acc_o;
    code_o = {result_o[27:24], result_o[11:8], result_o[23:16], result_o[7:0]};
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (valid_o && !clr_i) |=> valid_o);                                 // R8
  AST_FROZEN_RESULT: assert property (@(posedge clk) disable iff (!rst_sn)
    (valid_o && !clr_i) |=> $stable(result_o));                       // R8
  AST_CLR_INVALID: assert property (@(posedge clk) disable iff (!rst_sn)
    clr_i |=> !valid_o);                                              // R9
  AST_OTHER_CS: assert property (@(posedge clk) disable iff (!rst_sn)
    (!clr_i && beat_vld_i && beat_cs_i != sel_cs_i) |=> $stable(result_o)); // R6

endmodule

// File: tb/tb_nand_hamming_ecc.sv
module tb_nand_hamming_ecc;
  logic        clk, rst_n, clr, en, x16, vld;
  logic [2:0]  sel_cs, bcs;
  logic [7:0]  size;
  logic [15:0] data;
  logic [31:0] result;
  logic [23:0] code;
  logic        valid;

  int checks = 0, errors = 0;
  int unsigned seed = 32'd20240611;

  logic [11:0] exp_e, exp_o;
  int          exp_cnt;
  logic        exp_valid;

  nand_hamming_ecc dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(en), .x16_i(x16),
    .sel_cs_i(sel_cs), .size_i(size), .beat_vld_i(vld), .beat_cs_i(bcs),
    .beat_data_i(data), .result_o(result), .code_o(code), .valid_o(valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  function automatic logic [31:0] exp_res();
    return {4'h0, exp_o, 4'h0, exp_e};
  endfunction

  function automatic logic [23:0] exp_code();
    logic [31:0] r;
    r = exp_res();
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Reference: every set bit toggles one parity of each level.
  task automatic add_byte(input int idx, input logic [7:0] b);
    for (int j = 0; j < 8; j++) begin
      if (b[j]) begin
        int a;
        a = idx * 8 + j;
        for (int k = 0; k < 12; k++) begin
          if (((a >> k) & 1) == 1) exp_o[k] = ~exp_o[k];
          else exp_e[k] = ~exp_e[k];
        end
      end
    end
  endtask

  task automatic model_beat(input logic c, input logic v, input logic [2:0] cs,
                            input logic [15:0] d);
    int total, step;
    total = (int'(size) + 1) * 2;
    step  = x16 ? 2 : 1;
    if (c) begin
      exp_e = '0; exp_o = '0; exp_cnt = 0; exp_valid = 1'b0;
    end else if (en && v && cs == sel_cs && !exp_valid && exp_cnt + step <= total) begin
      add_byte(exp_cnt, d[7:0]);
      if (x16) add_byte(exp_cnt + 1, d[15:8]);
      exp_cnt += step;
      if (exp_cnt == total) exp_valid = 1'b1;
    end
  endtask

  task automatic drive(input logic c, input logic v, input logic [2:0] cs,
                       input logic [15:0] d);
    @(negedge clk);
    clr = c; vld = v; bcs = cs; data = d;
    model_beat(c, v, cs, d);
  endtask

  task automatic settle();
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
  endtask

  task automatic chk_all(input string req);
    chk(req, result, exp_res());
    chk(req, {8'h0, code}, {8'h0, exp_code()});
    chk(req, {31'h0, valid}, {31'h0, exp_valid});
  endtask

  task automatic do_clear();
    drive(1'b1, 1'b0, 3'd0, 16'h0);
    settle();
  endtask

  initial begin
    clr = 0; en = 1; x16 = 0; vld = 0; sel_cs = 3'd2; bcs = 0; size = 0; data = 0;
    exp_e = '0; exp_o = '0; exp_cnt = 0; exp_valid = 0;
    void'($urandom(seed));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", result, 32'h0);
    chk("R1", {8'h0, code}, 32'h0);
    chk("R1", {31'h0, valid}, 32'h0);

    // R2 single bit at index 0 lights every even parity
    size = 8'd0; x16 = 1'b0; do_clear();
    drive(1'b0, 1'b1, sel_cs, 16'h0001);
    drive(1'b0, 1'b1, sel_cs, 16'h0000);
    settle();
    chk("R2", result, 32'h0000_0FFF);
    chk("R3", {8'h0, code}, 32'h000F_00FF);
    chk_all("R8");

    // R2 byte 0x80 at index 1: address 15
    do_clear();
    drive(1'b0, 1'b1, sel_cs, 16'h0000);
    drive(1'b0, 1'b1, sel_cs, 16'h0080);
    settle();
    chk("R2", result, 32'h000F_0FF0);

    // R5 x16 beat, low byte index 0, high byte index 1
    x16 = 1'b1; do_clear();
    drive(1'b0, 1'b1, sel_cs, 16'h8001);
    settle();
    chk("R5", result, 32'h000F_000F);
    chk("R8", {31'h0, valid}, 32'h1);

    // R8 beats after completion ignored
    drive(1'b0, 1'b1, sel_cs, 16'h1234);
    settle();
    chk("R8", result, 32'h000F_000F);

    // R9 clear wins over a same-cycle beat
    drive(1'b1, 1'b1, sel_cs, 16'hFFFF);
    settle();
    chk("R9", result, 32'h0);
    chk("R9", {31'h0, valid}, 32'h0);

    // R7 enable low: nothing absorbed, count unchanged
    x16 = 1'b0; size = 8'd1; do_clear();
    en = 1'b0;
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, sel_cs, 16'h00A5);
    settle();
    chk("R7", result, 32'h0);
    chk("R7", {31'h0, valid}, 32'h0);
    en = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, sel_cs, 16'(i * 37 + 1));
    settle();
    chk_all("R7");

    // R6 other chip select ignored
    do_clear();
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, 3'd5, 16'h00FF);
    settle();
    chk("R6", result, 32'h0);
    chk("R6", {31'h0, valid}, 32'h0);

    // R4 full block of 0xFF gives zero
    size = 8'd255; x16 = 1'b0; do_clear();
    for (int i = 0; i < 512; i++) drive(1'b0, 1'b1, sel_cs, 16'h00FF);
    settle();
    chk("R4", result, 32'h0);
    chk("R4", {8'h0, code}, 32'h0);
    chk("R4", {31'h0, valid}, 32'h1);

    // Random blocks, both widths, mixed chip selects and gaps
    for (int t = 0; t < 10; t++) begin
      int total;
      x16  = t[0];
      size = 8'($urandom % 40);
      do_clear();
      total = (int'(size) + 1) * 2;
      while (!exp_valid) begin
        logic [2:0] cs;
        cs = ($urandom % 10 < 6) ? sel_cs : 3'($urandom);
        drive(1'b0, ($urandom % 4) != 0, cs, 16'($urandom));
        if (exp_cnt == total - 1 - int'(x16) && !x16) begin
          settle();
          chk("R8", {31'h0, valid}, 32'h0);
        end
      end
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, sel_cs, 16'($urandom));
      settle();
      chk_all(x16 ? "R5" : "R2");
      chk("R3", {8'h0, code}, {8'h0, exp_code()});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule